// File: doc/BRIEF.md
# Per-Channel DS0 Substitution Unit

This block sits in the serial payload path of a T1 or E1 framer and works on one time slot at a time. It carries two serial lanes that share one bit clock and one frame sync. The transmit lane runs from the backplane to the line, and the receive lane runs from the line to the backplane. In either lane, any channel can have its eight bits replaced by an idle byte programmed for that channel. In the transmit lane, any set of channels can instead carry the same-numbered channel taken straight from the receive line input, which gives a per-channel loopback.

Each lane also has a monitor register. Once per frame it captures the outgoing byte of one selected channel. All settings are written through a simple byte-wide write port. Substitution adds no latency: each output bit is produced combinationally in the same bit period as its input bit.

Top module: `ds0sub_unit`

## Requirements
- R1: After reset every idle code, enable bitmap, loopback bitmap, channel select and both monitors are zero, so both outputs equal their inputs.
- R2: `fsync` marks the first bit period of a frame. In T1 mode (`e1_mode`=0) that period is the F-bit. The F-bit passes unchanged in both lanes, and slots 0..23 fill the following 192 periods. In E1 mode that period is the first bit of slot 0, and slots 0..31 fill 256 periods. Each slot is 8 bits, most significant bit first. Periods outside a frame's payload pass unchanged: before the first sync, and after the last slot until the next sync.
- R3: If transmit idle-enable bit n is set, the 8 bits of `tx_out` in slot n are the transmit idle code of channel n, MSB first.
- R4: If receive idle-enable bit n is set, the 8 bits of `rx_out` in slot n are the receive idle code of channel n, MSB first.
- R5: If loopback bit n is set and transmit idle-enable bit n is clear, `tx_out` in slot n equals `rx_in` in the same bit period. This is the raw line data, taken before any receive idle replacement. Any combination of channels may be looped.
- R6: If both transmit idle-enable bit n and loopback bit n are set, the idle code is sent.
- R7: A select value v monitors channel v+1, that is, slot v. One cycle after the last bit of slot v, the monitor of that lane holds the byte that lane output in slot v. At all other times the monitor holds its value.
- R8: In T1 mode a select value from 24 to 31 matches no slot, so that monitor keeps its old value.
- R9: Write map, with `wr_en` high and the write taking effect from the next bit period:
  - 0..31: transmit idle code for slots 0..31.
  - 32..63: receive idle code for slots 0..31.
  - 64..67: transmit idle-enable bytes.
  - 68..71: receive idle-enable bytes.
  - 72..75: loopback bytes.
  - 76: transmit select, `wr_data[4:0]`.
  - 77: receive select, `wr_data[4:0]`.
  - Writes to any other address change nothing.
- R10: In each 32-bit bitmap, byte k (base address + k) bit i controls slot 8k+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock shared by both lanes |
| rst_n | input | 1 | Asynchronous active-low reset |
| e1_mode | input | 1 | 1 = E1 frame (32 slots), 0 = T1 frame (F-bit + 24 slots) |
| fsync | input | 1 | High in the first bit period of each frame |
| tx_in | input | 1 | Serial data from the backplane |
| rx_in | input | 1 | Serial data from the line |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register write address |
| wr_data | input | 8 | Register write data |
| tx_out | output | 1 | Serial data toward the line |
| rx_out | output | 1 | Serial data toward the backplane |
| tx_mon | output | 8 | Captured transmit byte of the selected slot |
| rx_mon | output | 8 | Captured receive byte of the selected slot |

## Verification
A wrong slot or bit position shows up at the serial outputs in the same bit period it occurs. The idle bits land one period early or late, or on the wrong channel. An F-bit miscount in T1 shifts every slot of that frame. A fault in the enable or loopback bitmaps appears at the first bit of the affected slot. A monitor fault surfaces one period after the last bit of the selected slot, and stays visible for the whole following frame. Comparing every output in every period against a position-counting model therefore catches such faults within one frame.

// File: rtl/ds0sub_pkg.sv
package ds0sub_pkg;

   typedef enum logic [2:0] {
      RG_TXC, RG_RXC, RG_TXE, RG_RXE, RG_LPE, RG_TSEL, RG_RSEL, RG_NONE
   } region_e;

   // Address regions follow each other: two code tables, three bitmaps, two selects.
   function automatic region_e region_of(input int unsigned a,
                                         input int unsigned nch,
                                         input int unsigned nb);
      if (a < nch)                      return RG_TXC;
      else if (a < 2*nch)               return RG_RXC;
      else if (a < 2*nch + nb)          return RG_TXE;
      else if (a < 2*nch + 2*nb)        return RG_RXE;
      else if (a < 2*nch + 3*nb)        return RG_LPE;
      else if (a == 2*nch + 3*nb)       return RG_TSEL;
      else if (a == 2*nch + 3*nb + 1)   return RG_RSEL;
      else                              return RG_NONE;
   endfunction

   function automatic int unsigned region_base(input region_e r,
                                               input int unsigned nch,
                                               input int unsigned nb);
      case (r)
         RG_RXC:  return nch;
         RG_TXE:  return 2*nch;
         RG_RXE:  return 2*nch + nb;
         RG_LPE:  return 2*nch + 2*nb;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/ds0sub_regs.sv
module ds0sub_regs
   import ds0sub_pkg::*;
#(
   parameter int NCH = 32,
   parameter int CW  = 8,
   parameter int AW  = 7
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [AW-1:0]            wr_addr,
   input  logic [CW-1:0]            wr_data,
   output logic [NCH-1:0][CW-1:0]   tx_code,
   output logic [NCH-1:0][CW-1:0]   rx_code,
   output logic [NCH-1:0]           tx_ien,
   output logic [NCH-1:0]           rx_ien,
   output logic [NCH-1:0]           loop_en,
   output logic [$clog2(NCH)-1:0]   tx_sel,
   output logic [$clog2(NCH)-1:0]   rx_sel
);
   localparam int SLOT_W = $clog2(NCH);
   localparam int NB     = NCH / CW;
   localparam int NB_W   = $clog2(NB);

   logic [NB-1:0][CW-1:0] tx_ien_b, rx_ien_b, loop_b;
   region_e               rg;
   logic [AW-1:0]         off;

   always_comb begin
      rg  = region_of(int'(wr_addr), NCH, NB);
      off = wr_addr - AW'(region_base(rg, NCH, NB));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_code  <= '0;
         rx_code  <= '0;
         tx_ien_b <= '0;
         rx_ien_b <= '0;
         loop_b   <= '0;
         tx_sel   <= '0;
         rx_sel   <= '0;
      end else if (wr_en) begin
         case (rg)
            RG_TXC:  tx_code[off[SLOT_W-1:0]] <= wr_data;
            RG_RXC:  rx_code[off[SLOT_W-1:0]] <= wr_data;
            RG_TXE:  tx_ien_b[off[NB_W-1:0]]  <= wr_data;
            RG_RXE:  rx_ien_b[off[NB_W-1:0]]  <= wr_data;
            RG_LPE:  loop_b[off[NB_W-1:0]]    <= wr_data;
            RG_TSEL: tx_sel <= wr_data[SLOT_W-1:0];
            RG_RSEL: rx_sel <= wr_data[SLOT_W-1:0];
            default: ;
         endcase
      end
   end

   assign tx_ien  = tx_ien_b;
   assign rx_ien  = rx_ien_b;
   assign loop_en = loop_b;

endmodule

// File: rtl/ds0sub_slot_timer.sv
module ds0sub_slot_timer #(
   parameter int NCH      = 32,
   parameter int CW       = 8,
   parameter int T1_SLOTS = 24
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     e1_mode,
   input  logic                     fsync,
   output logic                     pay,
   output logic [$clog2(NCH)-1:0]   slot,
   output logic [$clog2(CW)-1:0]    bitn,
   output logic                     last
);
   localparam int SLOT_W = $clog2(NCH);
   localparam int BIT_W  = $clog2(CW);

   logic              act_q;
   logic [SLOT_W-1:0] slot_q;
   logic [BIT_W-1:0]  bit_q;
   logic [SLOT_W-1:0] end_slot;

   // A sync restarts the count at once; in T1 its period is the F-bit.
   always_comb begin
      if (fsync) begin
         pay  = e1_mode;
         slot = '0;
         bitn = '0;
      end else begin
         pay  = act_q;
         slot = slot_q;
         bitn = bit_q;
      end
      last     = pay && (bitn == BIT_W'(CW-1));
      end_slot = e1_mode ? SLOT_W'(NCH-1) : SLOT_W'(T1_SLOTS-1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         slot_q <= '0;
         bit_q  <= '0;
      end else if (fsync && !e1_mode) begin
         act_q  <= 1'b1;
         slot_q <= '0;
         bit_q  <= '0;
      end else if (pay) begin
         if (last) begin
            bit_q <= '0;
            if (slot == end_slot) begin
               act_q <= 1'b0;
            end else begin
               act_q  <= 1'b1;
               slot_q <= slot + 1'b1;
            end
         end else begin
            act_q  <= 1'b1;
            slot_q <= slot;
            bit_q  <= bitn + 1'b1;
         end
      end
   end

endmodule

// File: rtl/ds0sub_lane.sv
module ds0sub_lane #(
   parameter int NCH      = 32,
   parameter int CW       = 8,
   parameter bit HAS_LOOP = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     din,
   input  logic                     loop_din,
   input  logic                     pay,
   input  logic [$clog2(NCH)-1:0]   slot,
   input  logic [$clog2(CW)-1:0]    bitn,
   input  logic                     last,
   input  logic [NCH-1:0][CW-1:0]   code,
   input  logic [NCH-1:0]           ien,
   input  logic [NCH-1:0]           loop_en,
   input  logic [$clog2(NCH)-1:0]   sel,
   output logic                     dout,
   output logic [CW-1:0]            mon
);
   localparam int BIT_W = $clog2(CW);

   logic          sub_in;
   logic          idle_bit;
   logic [CW-2:0] shf;

   generate
      if (HAS_LOOP) begin : g_loop
         assign sub_in = (pay && loop_en[slot]) ? loop_din : din;
      end else begin : g_noloop
         logic unused_loop;
         assign unused_loop = ^{loop_din, loop_en};
         assign sub_in      = din;
      end
   endgenerate

   // Idle code goes out MSB first; idle takes precedence over loopback.
   assign idle_bit = code[slot][BIT_W'(CW-1) - bitn];
   assign dout     = (pay && ien[slot]) ? idle_bit : sub_in;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shf <= '0;
         mon <= '0;
      end else if (pay) begin
         shf <= {shf[CW-3:0], dout};
         if (last && (slot == sel))
            mon <= {shf, dout};
      end
   end

endmodule

// File: rtl/ds0sub_unit.sv
module ds0sub_unit #(
   parameter int NCH      = 32,
   parameter int CW       = 8,
   parameter int T1_SLOTS = 24,
   parameter int AW       = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          e1_mode,
   input  logic          fsync,
   input  logic          tx_in,
   input  logic          rx_in,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [CW-1:0] wr_data,
   output logic          tx_out,
   output logic          rx_out,
   output logic [CW-1:0] tx_mon,
   output logic [CW-1:0] rx_mon
);
   localparam int SLOT_W = $clog2(NCH);
   localparam int BIT_W  = $clog2(CW);
   localparam int NB     = NCH / CW;
   localparam int LAST_A = 2*NCH + 3*NB + 1;

   if ((1 << SLOT_W) != NCH) $error("NCH must be a power of two");
   if ((1 << BIT_W) != CW || CW < 4) $error("CW must be a power of two, at least 4");
   if (NB < 2 || NB * CW != NCH) $error("NCH must be a multiple of CW, at least two bytes");
   if (T1_SLOTS < 1 || T1_SLOTS > NCH) $error("T1_SLOTS out of range");
   if (LAST_A >= (1 << AW)) $error("AW too narrow for the register map");

   logic                    pay, last;
   logic [SLOT_W-1:0]       slot, tx_sel, rx_sel;
   logic [BIT_W-1:0]        bitn;
   logic [NCH-1:0][CW-1:0]  tx_code, rx_code;
   logic [NCH-1:0]          tx_ien, rx_ien, loop_en;

   ds0sub_regs #(.NCH(NCH), .CW(CW), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .tx_code(tx_code), .rx_code(rx_code), .tx_ien(tx_ien), .rx_ien(rx_ien),
      .loop_en(loop_en), .tx_sel(tx_sel), .rx_sel(rx_sel)
   );

   ds0sub_slot_timer #(.NCH(NCH), .CW(CW), .T1_SLOTS(T1_SLOTS)) u_tmr (
      .clk(clk), .rst_n(rst_n), .e1_mode(e1_mode), .fsync(fsync),
      .pay(pay), .slot(slot), .bitn(bitn), .last(last)
   );

   ds0sub_lane #(.NCH(NCH), .CW(CW), .HAS_LOOP(1'b1)) u_tx (
      .clk(clk), .rst_n(rst_n), .din(tx_in), .loop_din(rx_in),
      .pay(pay), .slot(slot), .bitn(bitn), .last(last),
      .code(tx_code), .ien(tx_ien), .loop_en(loop_en), .sel(tx_sel),
      .dout(tx_out), .mon(tx_mon)
   );

   ds0sub_lane #(.NCH(NCH), .CW(CW), .HAS_LOOP(1'b0)) u_rx (
      .clk(clk), .rst_n(rst_n), .din(rx_in), .loop_din(1'b0),
      .pay(pay), .slot(slot), .bitn(bitn), .last(last),
      .code(rx_code), .ien(rx_ien), .loop_en('0), .sel(rx_sel),
      .dout(rx_out), .mon(rx_mon)
   );

endmodule

// File: rtl/ds0sub_chk.sv
module ds0sub_chk #(
   parameter int NCH      = 32,
   parameter int CW       = 8,
   parameter int T1_SLOTS = 24
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     e1_mode,
   input logic                     fsync,
   input logic                     tx_in,
   input logic                     rx_in,
   input logic                     tx_out,
   input logic                     rx_out,
   input logic [CW-1:0]            tx_mon,
   input logic [CW-1:0]            rx_mon,
   input logic                     pay,
   input logic                     last,
   input logic [$clog2(NCH)-1:0]   slot,
   input logic [$clog2(CW)-1:0]    bitn,
   input logic [$clog2(NCH)-1:0]   tx_sel,
   input logic [$clog2(NCH)-1:0]   rx_sel,
   input logic [NCH-1:0][CW-1:0]   tx_code,
   input logic [NCH-1:0][CW-1:0]   rx_code,
   input logic [NCH-1:0]           tx_ien,
   input logic [NCH-1:0]           rx_ien,
   input logic [NCH-1:0]           loop_en
);
   localparam int BIT_W = $clog2(CW);

   // R2
   fbit_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fsync && !e1_mode) |-> (tx_out == tx_in && rx_out == rx_in));

   // R2
   slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pay |-> (int'(slot) < (e1_mode ? NCH : T1_SLOTS)));

   // R4
   rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pay && rx_ien[slot]) |-> (rx_out == rx_code[slot][BIT_W'(CW-1) - bitn]));

   // R5
   loop_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pay && loop_en[slot] && !tx_ien[slot]) |-> (tx_out == rx_in));

   // R6
   idle_over_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pay && tx_ien[slot] && loop_en[slot]) |-> (tx_out == tx_code[slot][BIT_W'(CW-1) - bitn]));

   // R7
   tx_mon_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(last && slot == tx_sel) |=> $stable(tx_mon));

   // R7
   rx_mon_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(last && slot == rx_sel) |=> $stable(rx_mon));

endmodule

bind ds0sub_unit ds0sub_chk #(.NCH(NCH), .CW(CW), .T1_SLOTS(T1_SLOTS)) u_chk (
   .clk(clk), .rst_n(rst_n), .e1_mode(e1_mode), .fsync(fsync),
   .tx_in(tx_in), .rx_in(rx_in), .tx_out(tx_out), .rx_out(rx_out),
   .tx_mon(tx_mon), .rx_mon(rx_mon), .pay(pay), .last(last),
   .slot(slot), .bitn(bitn), .tx_sel(tx_sel), .rx_sel(rx_sel),
   .tx_code(tx_code), .rx_code(rx_code), .tx_ien(tx_ien), .rx_ien(rx_ien),
   .loop_en(loop_en)
);

// File: tb/ds0sub_unit_tb.sv
module ds0sub_unit_tb;
   localparam time CLK_P = 10ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       e1_mode = 1'b0;
   logic       fsync = 1'b0;
   logic       tx_in = 1'b0, rx_in = 1'b0;
   logic       wr_en = 1'b0;
   logic [6:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       tx_out, rx_out;
   logic [7:0] tx_mon, rx_mon;

   always #(CLK_P/2) clk = ~clk;

   ds0sub_unit u_dut (
      .clk(clk), .rst_n(rst_n), .e1_mode(e1_mode), .fsync(fsync),
      .tx_in(tx_in), .rx_in(rx_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .tx_out(tx_out), .rx_out(rx_out), .tx_mon(tx_mon), .rx_mon(rx_mon)
   );

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   // Reference model state: frame position as a plain bit count since sync.
   int       m_txc[32], m_rxc[32];
   bit [31:0] m_tie, m_rie, m_lpe;
   int       m_tsel, m_rsel, m_pos, m_tacc, m_racc, m_tmon, m_rmon;
   int       wq_a[$], wq_d[$];
   logic [15:0] lf = 16'hACE1;

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < 32; i++) begin m_txc[i] = 0; m_rxc[i] = 0; end
      m_tie = '0; m_rie = '0; m_lpe = '0;
      m_tsel = 0; m_rsel = 0; m_pos = -1;
      m_tacc = 0; m_racc = 0; m_tmon = 0; m_rmon = 0;
   endtask

   // R9 / R10: the write map as the requirements give it.
   task automatic model_write(input int a, input int d);
      if (a < 32)       m_txc[a] = d;
      else if (a < 64)  m_rxc[a-32] = d;
      else if (a < 68)  m_tie[(a-64)*8 +: 8] = d[7:0];
      else if (a < 72)  m_rie[(a-68)*8 +: 8] = d[7:0];
      else if (a < 76)  m_lpe[(a-72)*8 +: 8] = d[7:0];
      else if (a == 76) m_tsel = d % 32;
      else if (a == 77) m_rsel = d % 32;
   endtask

   task automatic step(input bit fs);
      int cur, s, b, et, er, tb, rb, flen, wa, wd;
      bit payload, we;
      string ttag, rtag, mtag;
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      fsync = fs;
      tx_in = lf[0];
      rx_in = lf[7];
      we = (wq_a.size() > 0);
      wa = 0; wd = 0;
      if (we) begin wa = wq_a.pop_front(); wd = wq_d.pop_front(); end
      wr_en = we; wr_addr = 7'(wa); wr_data = 8'(wd);
      #1;
      cur = fs ? 0 : m_pos;
      if (e1_mode) begin
         payload = (cur >= 0);
         s = payload ? cur / 8 : 0;
         b = payload ? cur % 8 : 0;
         flen = 256;
      end else begin
         payload = (cur >= 1);
         s = payload ? (cur - 1) / 8 : 0;
         b = payload ? (cur - 1) % 8 : 0;
         flen = 193;
      end
      tb = int'(tx_in); rb = int'(rx_in);
      et = tb; er = rb; ttag = "R2 tx pass"; rtag = "R2 rx pass";
      if (payload) begin
         if (m_tie[s]) begin
            et = (m_txc[s] >> (7 - b)) & 1;
            ttag = m_lpe[s] ? "R6 idle over loop" : "R3/R10 tx idle";
         end else if (m_lpe[s]) begin
            et = rb; ttag = "R5 loopback";
         end
         if (m_rie[s]) begin
            er = (m_rxc[s] >> (7 - b)) & 1; rtag = "R4 rx idle";
         end
      end
      mtag = (!e1_mode && m_tsel >= 24) ? "R8 tx mon hold" : "R7 tx mon";
      chk(ttag, int'(tx_out), et);
      chk(rtag, int'(rx_out), er);
      chk(mtag, int'(tx_mon), m_tmon);
      mtag = (!e1_mode && m_rsel >= 24) ? "R8 rx mon hold" : "R7 rx mon";
      chk(mtag, int'(rx_mon), m_rmon);
      // advance the model across the coming clock edge
      if (payload) begin
         m_tacc = ((m_tacc << 1) | et) & 255;
         m_racc = ((m_racc << 1) | er) & 255;
         if (b == 7 && s == m_tsel) m_tmon = m_tacc;
         if (b == 7 && s == m_rsel) m_rmon = m_racc;
      end
      m_pos = (cur >= 0 && cur < flen - 1) ? cur + 1 : -1;
      if (we) model_write(wa, wd);
   endtask

   task automatic do_reset(input bit e1);
      @(negedge clk);
      rst_n = 1'b0; e1_mode = e1; fsync = 1'b0; wr_en = 1'b0;
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state at the ports
      chk("R1 tx_mon reset", int'(tx_mon), 0);
      chk("R1 rx_mon reset", int'(rx_mon), 0);
      chk("R1 tx pass", int'(tx_out), int'(tx_in));
      chk("R1 rx pass", int'(rx_out), int'(rx_in));
   endtask

   task automatic wr(input int a, input int d);
      wq_a.push_back(a); wq_d.push_back(d);
   endtask

   task automatic flush();
      while (wq_a.size() > 0) step(1'b0);
   endtask

   task automatic frames(input int n, input int len);
      for (int f = 0; f < n; f++)
         for (int k = 0; k < len; k++) step(k == 0);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // T1 phase
      do_reset(1'b0);
      frames(2, 193);                       // R1: defaults leave data untouched
      for (int i = 0; i < 32; i++) begin
         wr(i, (i * 37 + 11) & 255);
         wr(32 + i, (i * 91 + 3) & 255);
      end
      wr(64, 8'h85); wr(65, 8'h30); wr(66, 8'h01); wr(67, 8'h80);   // R10
      wr(68, 8'h12); wr(70, 8'h81);
      wr(72, 8'h05); wr(73, 8'hC0); wr(74, 8'h03);
      wr(76, 2); wr(77, 1);
      wr(127, 8'hFF);                       // R9: unmapped address
      flush();
      frames(3, 193);
      wr(76, 15); wr(77, 9);                // mid-frame select change
      frames(2, 193);
      frames(1, 213);                       // R2: gap after last slot
      wr(76, 26); wr(77, 31);               // R8
      frames(2, 193);
      wr(73, 8'hFF); wr(65, 8'h00); wr(76, 12);
      frames(2, 193);

      // E1 phase
      do_reset(1'b1);
      frames(1, 256);
      for (int i = 0; i < 32; i++) begin
         wr(i, (i * 53 + 7) & 255);
         wr(32 + i, (i * 29 + 100) & 255);
      end
      wr(64, 8'h01); wr(67, 8'hC0); wr(69, 8'h44); wr(71, 8'h80);
      wr(72, 8'h02); wr(74, 8'hF0); wr(75, 8'h40);
      wr(76, 31); wr(77, 0);
      flush();
      frames(3, 256);
      wr(76, 30); wr(77, 31);
      frames(2, 256);
      frames(1, 270);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule